// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital front end of a 10-bit voltage-output DAC. A host writes 16-bit command words over a three-wire serial port: an active-low select, a serial clock and a data line. The select, the serial clock and the data line are brought into the system clock domain through two-flop synchronisers. Data is taken on each detected falling edge of the serial clock. The word is acted on as soon as its sixteenth bit arrives, whether or not the select has gone high.

Each word carries a 2-bit mode and a 10-bit unsigned code. The mode chooses normal operation or one of three shutdown terminations. The block holds the code across every shutdown, so waking up restores the previous output. After a wake-up, a recovery timer keeps the latch closed for a set number of cycles. Data words that arrive in that window are dropped and recorded in a sticky flag. A second sticky flag records a select-high gap that was too short.

The analog parts (the resistor string, the buffer and the terminations) take the code, the powered-down flag and the termination select from this block. The system clock must run at least four times faster than the serial clock.

Top module: `sdac_ctrl`

## Requirements
- R1: After reset the outputs are: `dac_code` = 0, `pwr_down` = 1, `term_sel` = 2'b10 (100 kΩ to ground), `ready` = 1, `wr_err` = 0 and `cs_viol` = 0.
- R2: A falling edge of `cs_n` starts a frame. On each later falling edge of `sclk`, one bit of `din` is taken, most significant bit first.
- R3: The word is applied when its 16th bit is taken, even if `cs_n` stays low.
- R4: Once a frame has completed, further `sclk` edges while `cs_n` stays low are ignored. Only a new falling edge of `cs_n` starts another frame.
- R5: If `cs_n` rises before the 16th bit, the partial frame is discarded.
- R6: Word layout: bits [15:14] are the mode, bits [13:4] are the code and bits [3:0] are ignored. The mode values are 00 run, 01 shutdown with 1 kΩ to ground, 10 shutdown with 100 kΩ to ground, and 11 shutdown with a high-impedance output.
- R7: A shutdown word (mode ≠ 00) sets `term_sel` to the mode and sets `pwr_down` to 1. It leaves `dac_code` unchanged.
- R8: A run word received while powered down is a wake-up. It sets `pwr_down` to 0 and `term_sel` to 00, keeps the stored code and ignores the word's code field. It drives `ready` low for WAKE_CYC cycles.
- R9: A run word received while powered up with `ready` = 1 loads its code field into `dac_code`.
- R10: A run word received while powered up with `ready` = 0 is ignored, and `wr_err` is set. `wr_err` stays set until reset.
- R11: If `cs_n` falls after being high for fewer than CS_HI_MIN consecutive system-clock samples, `cs_viol` is set and stays set until reset. The frame itself is still received.
- R12: A shutdown word received during the wake-up window ends the window, so `ready` returns to 1.
- R13: When a `cs_n` or `sclk` pin value is first sampled at a rising clock edge, its effect shows on the outputs after the fourth rising edge, counting that sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, most significant bit first |
| dac_code | output | 10 | Stored DAC code |
| pwr_down | output | 1 | 1 while in any shutdown mode |
| term_sel | output | 2 | Output termination: 00 driven, 01 1 kΩ, 10 100 kΩ, 11 high impedance |
| ready | output | 1 | 1 when the DAC latch may be written |
| wr_err | output | 1 | Sticky flag: a data word was dropped during wake-up recovery |
| cs_viol | output | 1 | Sticky flag: the select-high gap was too short |

## Verification
A pin value first sampled at rising edge k reaches `dac_code`, `pwr_down`, `term_sel`, `wr_err` and `cs_viol` after edge k+3. `ready` falls at that same edge and rises again WAKE_CYC edges later. The bench model keeps a five-deep history of pin samples and works on the entry from three edges back, so its state lines up with these latencies. Outputs are compared against that model at every falling clock edge, half a cycle after any change. A directed check counts the four edges after the last data bit and confirms the code is unchanged on the first three and updated on the fourth.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;
  localparam int DAC_W   = 10;
  localparam int MODE_W  = 2;
  localparam int FRAME_W = 16;
  localparam int KEEP_W  = MODE_W + DAC_W;

  typedef enum logic [MODE_W-1:0] {
    MD_RUN    = 2'b00,
    MD_SD_1K  = 2'b01,
    MD_SD_100K = 2'b10,
    MD_SD_HIZ = 2'b11
  } sdac_mode_e;
endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/sdac_rx.sv
`timescale 1ns/1ps
module sdac_rx import sdac_pkg::*; #(
  parameter int CS_HI_MIN = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              din_s,
  output logic              word_vld,
  output logic [KEEP_W-1:0] word,
  output logic              viol_p
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int HI_W  = $clog2(CS_HI_MIN + 1);
  localparam int SR_W  = FRAME_W - 1;

  logic              cs_d, sclk_d;
  logic              armed, armed_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [SR_W-1:0]   sr, sr_n;
  logic [HI_W-1:0]   hi_cnt, hi_cnt_n;
  logic              vld_n, viol_n, word_en;
  logic              cs_fall, sclk_fall;

  assign cs_fall   = cs_d & ~cs_s;
  assign sclk_fall = sclk_d & ~sclk_s;

  always_comb begin
    armed_n = armed;
    cnt_n   = cnt;
    sr_n    = sr;
    vld_n   = 1'b0;
    viol_n  = 1'b0;
    word_en = 1'b0;
    if (cs_fall) begin
      armed_n = 1'b1;
      cnt_n   = '0;
      viol_n  = (hi_cnt < HI_W'(CS_HI_MIN));
    end else if (cs_s) begin
      armed_n = 1'b0;
    end else if (armed && sclk_fall) begin
      sr_n = {sr[SR_W-2:0], din_s};
      if (cnt == CNT_W'(FRAME_W - 1)) begin
        vld_n   = 1'b1;
        word_en = 1'b1;
        armed_n = 1'b0;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
    if (!cs_s)
      hi_cnt_n = '0;
    else if (hi_cnt < HI_W'(CS_HI_MIN))
      hi_cnt_n = hi_cnt + 1'b1;
    else
      hi_cnt_n = hi_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d     <= 1'b1;
      sclk_d   <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      sr       <= '0;
      hi_cnt   <= HI_W'(CS_HI_MIN);
      word_vld <= 1'b0;
      viol_p   <= 1'b0;
    end else begin
      cs_d     <= cs_s;
      sclk_d   <= sclk_s;
      armed    <= armed_n;
      cnt      <= cnt_n;
      sr       <= sr_n;
      hi_cnt   <= hi_cnt_n;
      word_vld <= vld_n;
      viol_p   <= viol_n;
    end
  end

  // kept field is frame bits [15:4]: taken from the shift register before the last bit lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word <= '0;
    else if (word_en)
      word <= sr[SR_W-1 -: KEEP_W];
  end
endmodule

// File: rtl/sdac_ctl.sv
`timescale 1ns/1ps
module sdac_ctl import sdac_pkg::*; #(
  parameter int WAKE_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [MODE_W-1:0] cmd_mode,
  input  logic [DAC_W-1:0]  cmd_code,
  input  logic              viol_p,
  output logic [DAC_W-1:0]  code,
  output sdac_mode_e        mode,
  output logic              ready,
  output logic              wr_err,
  output logic              cs_viol
);
  localparam int WK_W = $clog2(WAKE_CYC + 1);

  sdac_mode_e       mode_n, req_mode;
  logic [DAC_W-1:0] code_n;
  logic [WK_W-1:0]  wcnt, wcnt_n;
  logic             err_n, viol_n;

  assign req_mode = sdac_mode_e'(cmd_mode);
  assign ready    = (wcnt == '0);

  always_comb begin
    mode_n = mode;
    code_n = code;
    err_n  = wr_err;
    viol_n = cs_viol | viol_p;
    wcnt_n = (wcnt != '0) ? wcnt - 1'b1 : wcnt;
    if (cmd_vld) begin
      if (req_mode != MD_RUN) begin
        mode_n = req_mode;
        wcnt_n = '0;
      end else if (mode != MD_RUN) begin
        mode_n = MD_RUN;
        wcnt_n = WK_W'(WAKE_CYC);
      end else if (wcnt == '0) begin
        code_n = cmd_code;
      end else begin
        err_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MD_SD_100K;
      code    <= '0;
      wcnt    <= '0;
      wr_err  <= 1'b0;
      cs_viol <= 1'b0;
    end else begin
      mode    <= mode_n;
      code    <= code_n;
      wcnt    <= wcnt_n;
      wr_err  <= err_n;
      cs_viol <= viol_n;
    end
  end
endmodule

// File: rtl/sdac_ctrl.sv
`timescale 1ns/1ps
module sdac_ctrl import sdac_pkg::*; #(
  parameter int CS_HI_MIN = 20,
  parameter int WAKE_CYC  = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  output logic [DAC_W-1:0] dac_code,
  output logic             pwr_down,
  output logic [1:0]       term_sel,
  output logic             ready,
  output logic             wr_err,
  output logic             cs_viol
);
  logic              sclk_s, cs_s, din_s;
  logic              rx_vld, rx_viol;
  logic [KEEP_W-1:0] rx_word;
  logic [MODE_W-1:0] rx_mode;
  logic [DAC_W-1:0]  rx_code;
  sdac_mode_e        cur_mode;

  sdac_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, cs_n, din}),
    .q     ({sclk_s, cs_s, din_s})
  );

  sdac_rx #(.CS_HI_MIN(CS_HI_MIN)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .cs_s     (cs_s),
    .din_s    (din_s),
    .word_vld (rx_vld),
    .word     (rx_word),
    .viol_p   (rx_viol)
  );

  assign rx_mode = rx_word[KEEP_W-1 -: MODE_W];
  assign rx_code = rx_word[DAC_W-1:0];

  sdac_ctl #(.WAKE_CYC(WAKE_CYC)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (rx_vld),
    .cmd_mode (rx_mode),
    .cmd_code (rx_code),
    .viol_p   (rx_viol),
    .code     (dac_code),
    .mode     (cur_mode),
    .ready    (ready),
    .wr_err   (wr_err),
    .cs_viol  (cs_viol)
  );

  assign pwr_down = (cur_mode != MD_RUN);
  assign term_sel = cur_mode;
endmodule

// File: rtl/sdac_ctrl_chk.sv
`timescale 1ns/1ps
module sdac_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_vld,
  input logic [1:0] rx_mode,
  input logic [9:0] dac_code,
  input logic       pwr_down,
  input logic       ready,
  input logic       wr_err,
  input logic       cs_viol
);
  a_r7_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_mode != 2'b00) |=> $stable(dac_code));

  a_r9_code_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code) |-> (!pwr_down && $past(ready) && $past(rx_vld)));

  a_r8_wake_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !ready);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  a_r11_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cs_viol |=> cs_viol);

  a_r12_shutdown_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_mode != 2'b00) |=> ready);
endmodule

bind sdac_ctrl sdac_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_vld   (rx_vld),
  .rx_mode  (rx_mode),
  .dac_code (dac_code),
  .pwr_down (pwr_down),
  .ready    (ready),
  .wr_err   (wr_err),
  .cs_viol  (cs_viol)
);

// File: tb/sdac_ctrl_bench.sv
`timescale 1ns/1ps
module sdac_ctrl_bench;
  localparam int CS_MIN = 20;
  localparam int WAKE   = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       din = 1'b0;
  logic [9:0] dac_code;
  logic       pwr_down, ready, wr_err, cs_viol;
  logic [1:0] term_sel;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdac_ctrl #(.CS_HI_MIN(CS_MIN), .WAKE_CYC(WAKE)) u_sdac_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dac_code(dac_code), .pwr_down(pwr_down), .term_sel(term_sel),
    .ready(ready), .wr_err(wr_err), .cs_viol(cs_viol)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model: pin history, frame decode, mode/timer state
  int h_cs[5], h_sk[5], h_d[5];
  int m_armed, m_cnt, m_sr, m_hi, m_code, m_mode, m_wcnt, m_err, m_viol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin h_cs[i] = 1; h_sk[i] = 0; h_d[i] = 0; end
      m_armed = 0; m_cnt = 0; m_sr = 0; m_hi = CS_MIN;
      m_code = 0; m_mode = 2; m_wcnt = 0; m_err = 0; m_viol = 0;
    end else begin
      int done_w, rdy, md, cd;
      for (int i = 4; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_sk[i] = h_sk[i-1]; h_d[i] = h_d[i-1];
      end
      h_cs[0] = cs_n; h_sk[0] = sclk; h_d[0] = din;
      done_w = 0;
      if (h_cs[4] == 1 && h_cs[3] == 0) begin
        m_armed = 1; m_cnt = 0;
        if (m_hi < CS_MIN) m_viol = 1;
      end else if (h_cs[3] == 1) begin
        m_armed = 0;
      end else if (m_armed == 1 && h_sk[4] == 1 && h_sk[3] == 0) begin
        m_sr = ((m_sr << 1) | h_d[3]) & 16'hFFFF;
        m_cnt++;
        if (m_cnt == 16) begin done_w = 1; m_armed = 0; end
      end
      m_hi = (h_cs[3] == 1) ? ((m_hi < CS_MIN) ? m_hi + 1 : m_hi) : 0;
      rdy = (m_wcnt == 0);
      if (m_wcnt > 0) m_wcnt--;
      if (done_w == 1) begin
        md = (m_sr >> 14) & 3;
        cd = (m_sr >> 4) & 10'h3FF;
        if (md != 0) begin m_mode = md; m_wcnt = 0; end
        else if (m_mode != 0) begin m_mode = 0; m_wcnt = WAKE; end
        else if (rdy == 1) m_code = cd;
        else m_err = 1;
      end
    end
  end

  // compare every cycle, half a period after the outputs may change (R13 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 dac_code vs model", dac_code, m_code);
      chk("R7 pwr_down vs model", pwr_down, (m_mode != 0));
      chk("R7 term_sel vs model", term_sel, m_mode);
      chk("R8 ready vs model", ready, (m_wcnt == 0));
      chk("R10 wr_err vs model", wr_err, m_err);
      chk("R11 cs_viol vs model", cs_viol, m_viol);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input int extra, input bit rel);
    cs_n = 1'b0;
    idle(4);
    for (int i = 0; i < nbits; i++) begin
      din = w[15-i]; sclk = 1'b1; idle(4); sclk = 1'b0; idle(4);
    end
    for (int i = 0; i < extra; i++) begin
      din = 1'b1; sclk = 1'b1; idle(4); sclk = 1'b0; idle(4);
    end
    if (rel) cs_n = 1'b1;
  endtask

  task automatic send(input logic [15:0] w);
    frame(w, 16, 0, 1'b1);
    idle(30);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 code", dac_code, 0);
    chk("R1 pwr_down", pwr_down, 1);
    chk("R1 term_sel", term_sel, 2);
    chk("R1 ready", ready, 1);
    chk("R1 wr_err", wr_err, 0);
    chk("R1 cs_viol", cs_viol, 0);
    idle(30);

    // R8 wake-up from reset state; code field ignored
    send({2'b00, 10'h3C3, 4'h0});
    chk("R8 wake pwr_down", pwr_down, 0);
    chk("R8 wake term_sel", term_sel, 0);
    chk("R8 wake keeps code", dac_code, 0);
    chk("R8 ready low", ready, 0);
    // R10 data word inside the wake window
    send({2'b00, 10'h155, 4'hF});
    chk("R10 dropped code", dac_code, 0);
    chk("R10 wr_err set", wr_err, 1);
    idle(WAKE + 10);
    chk("R8 ready back", ready, 1);

    // R9 R6 R2 data write, low nibble ignored
    send({2'b00, 10'h2A5, 4'h9});
    chk("R9 R6 R2 code loaded", dac_code, 10'h2A5);

    // R7 shutdown modes keep the code
    send({2'b01, 10'h3FF, 4'h0});
    chk("R7 code kept", dac_code, 10'h2A5);
    chk("R7 term 1k", term_sel, 1);
    chk("R7 pwr_down", pwr_down, 1);
    send({2'b11, 10'h000, 4'h0});
    chk("R7 term hiz", term_sel, 3);
    send({2'b10, 10'h001, 4'h0});
    chk("R7 term 100k", term_sel, 2);

    // R8 wake restores code; R12 shutdown inside the window
    send({2'b00, 10'h0AA, 4'h0});
    chk("R8 restored code", dac_code, 10'h2A5);
    chk("R8 ready low again", ready, 0);
    send({2'b01, 10'h0AA, 4'h0});
    chk("R12 ready restored", ready, 1);
    chk("R12 term 1k", term_sel, 1);
    send({2'b00, 10'h000, 4'h0});
    idle(WAKE + 10);

    // R5 aborted frame
    frame({2'b00, 10'h111, 4'h0}, 8, 0, 1'b1);
    idle(30);
    chk("R5 partial discarded", dac_code, 10'h2A5);
    send({2'b00, 10'h1C3, 4'h0});
    chk("R5 next frame ok", dac_code, 10'h1C3);

    // R3 R4 select held low, extra clocks ignored
    frame({2'b00, 10'h3A1, 4'h0}, 16, 16, 1'b0);
    idle(30);
    chk("R3 applied with cs low", dac_code, 10'h3A1);
    chk("R4 extra clocks ignored", pwr_down, 0);
    chk("R11 no viol so far", cs_viol, 0);

    // R11 short select-high gap
    cs_n = 1'b1;
    idle(3);
    send({2'b00, 10'h05A, 4'h0});
    chk("R11 viol set", cs_viol, 1);
    chk("R11 frame still taken", dac_code, 10'h05A);

    // R13 latency after the last data bit
    frame({2'b00, 10'h2F0, 4'h0}, 15, 0, 1'b0);
    din = 1'b0; sclk = 1'b1; idle(4); sclk = 1'b0;
    idle(3);
    chk("R13 old code at edge 3", dac_code, 10'h05A);
    idle(1);
    chk("R13 new code at edge 4", dac_code, 10'h2F0);
    cs_n = 1'b1;
    idle(30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule